// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block is a synthesizable traffic source for bring-up and link testing. After reset it sends a programmed number of complete Ethernet frames on an 8-bit GMII-style transmit interface (data, enable, error) and then stays idle. Each frame carries a preamble, start delimiter, fixed addresses, optional VLAN tags, a length/type field holding the payload length, an incrementing payload, optional zero padding and a CRC-32 frame check sequence.

The payload length starts at a configured value and grows by a fixed step from frame to frame. When the next length would pass a configured maximum, it returns to the start value. That maximum may lie above any MAC limit, so oversize frames can be produced on purpose. A frame-type rotation can mix in single-tagged and double-tagged frames. The inter-packet gap is fixed or follows a per-frame sweep. One error cycle per frame can be injected, and a pause request can hold back new frames. Configuration inputs are static: change them only while reset is asserted.

The controller is a single state machine. States: WAIT (ready to launch), PRE (preamble and SFD), HDR (addresses, tags, length/type), PAY (payload), PAD (zero fill), FCS (check sequence), GAP (inter-packet idle), DONE (all frames sent). Transitions: WAIT→PRE when frames remain and no pause holds; WAIT→DONE when none remain; PRE→HDR after 8 bytes; HDR→PAY, or →PAD on a zero payload, or →FCS on a zero payload with no pad; PAY→PAD or →FCS; PAD→FCS; FCS→GAP after 4 bytes; GAP→PRE, →WAIT (pause active) or →DONE at the end of the gap.

Top module: `eth_test_frame_gen`

## Requirements
- R1: After reset exactly `cfg_frame_count` frames are sent. The block then keeps `gmii_tx_en` low and holds `tx_done` high. A count of 0 sends nothing.
- R2: Frame k (from 0) has payload length start + k·step while no wrap occurs. The length/type field carries that length, big-endian.
- R3: When the previous length plus step exceeds `cfg_len_max`, the length returns to `cfg_len_start`. Lengths above 1518 bytes are still generated in full.
- R4: Frame bytes, in order: seven 0x55, then 0xD5, destination 0x0A1B2C3D4E5F, source 0x020000ABCDEF (both most significant byte first), the tags of R7, the 2-byte length/type, then payload byte i = i mod 256.
- R5: The last 4 bytes are the reflected CRC-32 (poly 0x04C11DB7, init all ones, final inversion) over destination through pad, least significant byte first.
- R6: With `cfg_pad_en` = 1, frames whose destination-through-FCS span is below 64 bytes get zero bytes before the FCS to make it exactly 64. With 0, nothing is added.
- R7: With `cfg_vlan_every` = N > 0, the rotation is N basic frames, one single-tagged frame (0x8100, TCI 0x0123), then one double-tagged frame (0x88A8, TCI 0x2064, 0x8100, TCI 0x0123), and it repeats. With N = 0 all frames are basic. Tags sit between the source address and the length/type field.
- R8: With `cfg_var_gap_en` = 0, exactly 12 idle cycles separate consecutive frames.
- R9: With `cfg_var_gap_en` = 1, the gap after frame k is 12 + ((k+1) mod 8) cycles.
- R10: With `cfg_err_en` = 1, `gmii_tx_er` is high for exactly one cycle per frame, on the low byte of the length/type field. With 0 it stays low.
- R11: With `cfg_pause_en` = 1, no frame starts while `pause_req` is high. A frame in progress is never cut short. Sending resumes on the cycle after the first cycle with the request low.
- R12: With `cfg_pause_en` = 0, `pause_req` has no effect on frames or gaps.
- R13: During reset `gmii_tx_en`, `gmii_tx_er` and `tx_done` are low. `gmii_tx_er` is never high without `gmii_tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_frame_count | input | 16 | Number of frames to send |
| cfg_len_start | input | 12 | First payload length |
| cfg_len_step | input | 12 | Payload length increment |
| cfg_len_max | input | 12 | Largest payload length before wrap |
| cfg_pad_en | input | 1 | Pad short frames to 64 bytes |
| cfg_vlan_every | input | 4 | Basic frames per VLAN rotation; 0 disables tags |
| cfg_var_gap_en | input | 1 | Use swept gap instead of constant |
| cfg_err_en | input | 1 | Inject one error cycle per frame |
| cfg_pause_en | input | 1 | Obey pause_req |
| pause_req | input | 1 | Flow-control hold request |
| gmii_txd | output | 8 | Transmit byte |
| gmii_tx_en | output | 1 | Byte valid (preamble through FCS) |
| gmii_tx_er | output | 1 | Error marker |
| tx_done | output | 1 | All frames sent |

## Verification
The outputs decode the state register directly, so each byte appears in the cycle after the clock edge that enters its state and count. The first preamble byte follows reset release by one cycle. A launch follows the last gap cycle or the first cycle with pause low with no extra delay. The bench samples every output on the falling edge and measures gaps by counting idle samples between the last FCS byte and the next preamble byte, so a gap of G cycles reads as exactly G. Pause checks count from the falling edge at which the request is dropped and allow the one launch cycle.

// File: rtl/eth_tfg_pkg.sv
package eth_tfg_pkg;

    typedef enum logic [2:0] {
        S_WAIT, S_PRE, S_HDR, S_PAY, S_PAD, S_FCS, S_GAP, S_DONE
    } tfg_state_t;

    typedef enum logic [1:0] {
        K_BASIC, K_SINGLE, K_STACKED
    } frame_kind_t;

    // One byte of the reflected CRC-32 (poly 0x04C11DB7 reversed = 0xEDB88320)
    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                               input logic [7:0]  d);
        logic [31:0] c;
        c = c_in ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/tfg_frame_plan.sv
module tfg_frame_plan
    import eth_tfg_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 16,
    parameter int VLAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [LEN_W-1:0]  cfg_start,
    input  logic [LEN_W-1:0]  cfg_step,
    input  logic [LEN_W-1:0]  cfg_max,
    input  logic [VLAN_W-1:0] cfg_vlan,
    output logic [LEN_W-1:0]  cur_len,
    output frame_kind_t       cur_kind,
    output logic              more,
    output logic [CNT_W-1:0]  sent
);

    logic [LEN_W:0]  len_sum;
    logic [VLAN_W:0] pos;
    logic [VLAN_W:0] pos_single;
    logic [VLAN_W:0] pos_last;

    assign len_sum    = {1'b0, cur_len} + {1'b0, cfg_step};
    assign pos_single = {1'b0, cfg_vlan};
    assign pos_last   = pos_single + (VLAN_W+1)'(1);
    assign more       = (sent != cfg_count);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_len <= cfg_start;
            pos     <= '0;
            sent    <= '0;
        end else if (advance) begin
            cur_len <= (len_sum > {1'b0, cfg_max}) ? cfg_start : len_sum[LEN_W-1:0];
            pos     <= (cfg_vlan == '0 || pos == pos_last) ? '0 : pos + (VLAN_W+1)'(1);
            sent    <= sent + CNT_W'(1);
        end
    end

    always_comb begin
        if (cfg_vlan == '0 || pos < pos_single) cur_kind = K_BASIC;
        else if (pos == pos_single)             cur_kind = K_SINGLE;
        else                                    cur_kind = K_STACKED;
    end

endmodule

// File: rtl/tfg_crc32.sv
module tfg_crc32
    import eth_tfg_pkg::*;
(
    input  logic        clk,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (init)    crc_q <= 32'hFFFF_FFFF;
        else if (en) crc_q <= crc32_byte(crc_q, din);
    end

endmodule

// File: rtl/eth_test_frame_gen.sv
module eth_test_frame_gen
    import eth_tfg_pkg::*;
#(
    parameter int          LEN_W     = 12,
    parameter int          CNT_W     = 16,
    parameter int          VLAN_W    = 4,
    parameter int          IPG       = 12,
    parameter logic [47:0] DST_MAC   = 48'h0A1B2C3D4E5F,
    parameter logic [47:0] SRC_MAC   = 48'h020000ABCDEF,
    parameter logic [15:0] OUTER_TCI = 16'h2064,
    parameter logic [15:0] INNER_TCI = 16'h0123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_frame_count,
    input  logic [LEN_W-1:0]  cfg_len_start,
    input  logic [LEN_W-1:0]  cfg_len_step,
    input  logic [LEN_W-1:0]  cfg_len_max,
    input  logic              cfg_pad_en,
    input  logic [VLAN_W-1:0] cfg_vlan_every,
    input  logic              cfg_var_gap_en,
    input  logic              cfg_err_en,
    input  logic              cfg_pause_en,
    input  logic              pause_req,
    output logic [7:0]        gmii_txd,
    output logic              gmii_tx_en,
    output logic              gmii_tx_er,
    output logic              tx_done
);

    localparam int CW       = LEN_W + 2;
    localparam int MIN_BODY = 60;   // 64-byte minimum minus 4 FCS bytes

    tfg_state_t       state, nxt;
    logic [CW-1:0]    cnt, cnt_n;
    logic             advance;
    logic [LEN_W-1:0] cur_len;
    frame_kind_t      cur_kind;
    logic             more;
    logic [CNT_W-1:0] sent;
    logic [31:0]      crc_q;
    logic             held;
    logic [CW-1:0]    hdr_len, len_ext, body_len, pad_len, gap_len;
    logic [4:0]       hb, rel, tag_n;
    logic [63:0]      tagv;
    logic [15:0]      len16;

    tfg_frame_plan #(.LEN_W(LEN_W), .CNT_W(CNT_W), .VLAN_W(VLAN_W)) u_plan (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .cfg_count(cfg_frame_count), .cfg_start(cfg_len_start),
        .cfg_step(cfg_len_step), .cfg_max(cfg_len_max), .cfg_vlan(cfg_vlan_every),
        .cur_len(cur_len), .cur_kind(cur_kind), .more(more), .sent(sent)
    );

    tfg_crc32 u_crc (
        .clk(clk),
        .init(state == S_PRE),
        .en(state == S_HDR || state == S_PAY || state == S_PAD),
        .din(gmii_txd),
        .crc_q(crc_q)
    );

    // frame geometry
    always_comb begin
        unique case (cur_kind)
            K_STACKED: begin hdr_len = CW'(22); tag_n = 5'd8; tagv = {16'h88A8, OUTER_TCI, 16'h8100, INNER_TCI}; end
            K_SINGLE:  begin hdr_len = CW'(18); tag_n = 5'd4; tagv = {16'h8100, INNER_TCI, 32'h0}; end
            default:   begin hdr_len = CW'(14); tag_n = 5'd0; tagv = 64'h0; end
        endcase
        len_ext  = CW'(cur_len);
        len16    = 16'(cur_len);
        body_len = hdr_len + len_ext;
        pad_len  = (cfg_pad_en && body_len < CW'(MIN_BODY)) ? CW'(MIN_BODY) - body_len : '0;
        gap_len  = CW'(IPG) + (cfg_var_gap_en ? CW'(sent[2:0]) : '0);
        held     = cfg_pause_en && pause_req;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_WAIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_n   = cnt + CW'(1);
        advance = 1'b0;
        unique case (state)
            S_WAIT: begin
                cnt_n = '0;
                if (!more)     nxt = S_DONE;
                else if (!held) nxt = S_PRE;
            end
            S_PRE: if (cnt == CW'(7)) begin
                cnt_n = '0;
                nxt   = S_HDR;
            end
            S_HDR: if (cnt == hdr_len - CW'(1)) begin
                cnt_n = '0;
                nxt   = (len_ext != '0) ? S_PAY : (pad_len != '0) ? S_PAD : S_FCS;
            end
            S_PAY: if (cnt == len_ext - CW'(1)) begin
                cnt_n = '0;
                nxt   = (pad_len != '0) ? S_PAD : S_FCS;
            end
            S_PAD: if (cnt == pad_len - CW'(1)) begin
                cnt_n = '0;
                nxt   = S_FCS;
            end
            S_FCS: if (cnt == CW'(3)) begin
                cnt_n   = '0;
                nxt     = S_GAP;
                advance = 1'b1;
            end
            S_GAP: if (cnt == gap_len - CW'(1)) begin
                cnt_n = '0;
                if (!more)    nxt = S_DONE;
                else if (held) nxt = S_WAIT;
                else          nxt = S_PRE;
            end
            S_DONE: cnt_n = '0;
        endcase
    end

    // outputs
    always_comb begin
        hb         = cnt[4:0];
        rel        = hb - 5'd12;
        gmii_txd   = 8'h00;
        gmii_tx_en = 1'b0;
        gmii_tx_er = 1'b0;
        tx_done    = (state == S_DONE);
        unique case (state)
            S_PRE: begin
                gmii_tx_en = 1'b1;
                gmii_txd   = (cnt == CW'(7)) ? 8'hD5 : 8'h55;
            end
            S_HDR: begin
                gmii_tx_en = 1'b1;
                gmii_tx_er = cfg_err_en && (cnt == hdr_len - CW'(1));
                if (hb < 5'd6)       gmii_txd = 8'(DST_MAC >> (8 * (5 - hb)));
                else if (hb < 5'd12) gmii_txd = 8'(SRC_MAC >> (8 * (11 - hb)));
                else if (rel < tag_n) gmii_txd = 8'(tagv >> (8 * (7 - rel)));
                else                 gmii_txd = (rel == tag_n) ? len16[15:8] : len16[7:0];
            end
            S_PAY: begin
                gmii_tx_en = 1'b1;
                gmii_txd   = cnt[7:0];
            end
            S_PAD: gmii_tx_en = 1'b1;
            S_FCS: begin
                gmii_tx_en = 1'b1;
                gmii_txd   = 8'(~crc_q >> (8 * cnt[1:0]));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tfg_checker.sv
module tfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] gmii_txd,
    input logic       gmii_tx_en,
    input logic       gmii_tx_er,
    input logic       tx_done,
    input logic       cfg_pause_en,
    input logic       pause_req
);

    // R13
    er_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gmii_tx_er |-> gmii_tx_en);

    // R10
    er_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gmii_tx_er |=> !gmii_tx_er);

    // R1
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !gmii_tx_en);

    // R1
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> tx_done);

    // R4
    preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmii_tx_en) |-> gmii_txd == 8'h55);

    // R11
    no_start_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmii_tx_en) |-> !$past(cfg_pause_en && pause_req));

endmodule

bind eth_test_frame_gen tfg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en),
    .gmii_tx_er(gmii_tx_er), .tx_done(tx_done), .cfg_pause_en(cfg_pause_en),
    .pause_req(pause_req)
);

// File: tb/eth_test_frame_gen_tb.sv
`timescale 1ns/1ps
module eth_test_frame_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_frame_count = 16'd0;
    logic [11:0] cfg_len_start = 12'd0, cfg_len_step = 12'd0, cfg_len_max = 12'd0;
    logic        cfg_pad_en = 1'b0, cfg_var_gap_en = 1'b0, cfg_err_en = 1'b0, cfg_pause_en = 1'b0;
    logic [3:0]  cfg_vlan_every = 4'd0;
    logic        pause_req = 1'b0;
    logic [7:0]  gmii_txd;
    logic        gmii_tx_en, gmii_tx_er, tx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] exp_b [0:2199];
    logic [7:0] got_b [0:2199];
    int exp_n, got_n, er_pos, er_cnt;

    always #2.5 clk = ~clk;

    eth_test_frame_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_frame_count(cfg_frame_count),
        .cfg_len_start(cfg_len_start), .cfg_len_step(cfg_len_step), .cfg_len_max(cfg_len_max),
        .cfg_pad_en(cfg_pad_en), .cfg_vlan_every(cfg_vlan_every), .cfg_var_gap_en(cfg_var_gap_en),
        .cfg_err_en(cfg_err_en), .cfg_pause_en(cfg_pause_en), .pause_req(pause_req),
        .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en), .gmii_tx_er(gmii_tx_er), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in ^ {24'h0, d};
        for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    task automatic push(input logic [7:0] b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic build(input int len, input int kind, output int hdr);
        logic [47:0] da, sa;
        logic [31:0] crc;
        int body;
        da = 48'h0A1B2C3D4E5F;
        sa = 48'h020000ABCDEF;
        exp_n = 0;
        for (int i = 0; i < 7; i++) push(8'h55);
        push(8'hD5);
        for (int i = 0; i < 6; i++) push(da[8*(5-i) +: 8]);
        for (int i = 0; i < 6; i++) push(sa[8*(5-i) +: 8]);
        if (kind == 2) begin push(8'h88); push(8'hA8); push(8'h20); push(8'h64); end
        if (kind >= 1) begin push(8'h81); push(8'h00); push(8'h01); push(8'h23); end
        push(8'(len >> 8));
        push(8'(len));
        hdr = 14 + 4 * kind;
        for (int i = 0; i < len; i++) push(8'(i));
        body = hdr + len;
        if (cfg_pad_en) for (int i = body; i < 60; i++) push(8'h00);
        crc = 32'hFFFF_FFFF;
        for (int i = 8; i < exp_n; i++) crc = crc_step(crc, exp_b[i]);
        crc = ~crc;
        for (int i = 0; i < 4; i++) push(crc[8*i +: 8]);
    endtask

    task automatic wait_start(output int idle);
        idle = 0;
        while (!gmii_tx_en && idle < 5000) begin
            idle++;
            @(negedge clk);
        end
    endtask

    task automatic capture();
        got_n = 0; er_pos = -1; er_cnt = 0;
        while (gmii_tx_en && got_n < 2200) begin
            got_b[got_n] = gmii_txd;
            if (gmii_tx_er) begin er_cnt++; er_pos = got_n; end
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R13
        chk(!gmii_tx_en && !gmii_tx_er && !tx_done, "R13 outputs low in reset",
            {gmii_tx_en, gmii_tx_er, tx_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Runs one configuration from reset release; pause_probe adds the R11 checks.
    task automatic run_frames(input bit pause_probe);
        int len, pos, kind, idle, hdr, mism, first_bad, exp_gap, quiet;
        len = int'(cfg_len_start);
        pos = 0;
        for (int k = 0; k < int'(cfg_frame_count); k++) begin
            kind = (cfg_vlan_every == 0 || pos < int'(cfg_vlan_every)) ? 0 :
                   (pos == int'(cfg_vlan_every)) ? 1 : 2;
            wait_start(idle);
            if (!gmii_tx_en) begin
                chk(1'b0, "R1 frame missing", k, int'(cfg_frame_count));
                return;
            end
            if (k == 0 && pause_probe) begin
                // R11 launch right after release
                chk(idle <= 1, "R11 resume delay", idle, 1);
                pause_req = 1'b1;
                fork
                    begin repeat (200) @(negedge clk); pause_req = 1'b0; end
                join_none
            end
            if (k > 0) begin
                exp_gap = 12 + (cfg_var_gap_en ? (k % 8) : 0);
                if (k == 1 && pause_probe)
                    chk(idle >= 100, "R11 pause held next start", idle, 100);
                else
                    chk(idle == exp_gap, "R8/R9/R12 gap", idle, exp_gap);
            end
            capture();
            build(len, kind, hdr);
            chk(got_n == exp_n, "R2/R3/R6/R7 frame length", got_n, exp_n);
            mism = 0; first_bad = -1;
            for (int i = 0; i < exp_n && i < got_n; i++)
                if (got_b[i] !== exp_b[i]) begin
                    mism++;
                    if (first_bad < 0) first_bad = i;
                end
            chk(mism == 0, "R4/R5/R6/R7 content, first bad index in got", first_bad, -1);
            if (cfg_err_en)
                chk(er_cnt == 1 && er_pos == 8 + hdr - 1, "R10 error position", er_pos, 8 + hdr - 1);
            else
                chk(er_cnt == 0, "R10 no error", er_cnt, 0);
            if (len + int'(cfg_len_step) > int'(cfg_len_max)) len = int'(cfg_len_start);
            else len = len + int'(cfg_len_step);
            if (cfg_vlan_every == 0 || pos == int'(cfg_vlan_every) + 1) pos = 0;
            else pos++;
        end
        quiet = 0;
        repeat (60) begin
            if (gmii_tx_en) quiet++;
            @(negedge clk);
        end
        chk(quiet == 0 && tx_done, "R1 idle and done after last frame", quiet, 0);
    endtask

    task automatic setup(input int n, input int st, input int sp, input int mx,
                         input bit pad, input int vl, input bit vg, input bit er, input bit pe);
        cfg_frame_count = 16'(n);
        cfg_len_start   = 12'(st);
        cfg_len_step    = 12'(sp);
        cfg_len_max     = 12'(mx);
        cfg_pad_en      = pad;
        cfg_vlan_every  = 4'(vl);
        cfg_var_gap_en  = vg;
        cfg_err_en      = er;
        cfg_pause_en    = pe;
    endtask

    initial begin
        int still;
        @(negedge clk);
        // defaults: R1 R2 R4 R5 R8
        setup(5, 100, 1, 1500, 1, 0, 0, 0, 0);
        do_reset(); run_frames(0);
        // wrap, rotation, padding: R3 R6 R7
        setup(6, 10, 7, 30, 1, 2, 0, 0, 0);
        do_reset(); run_frames(0);
        // unpadded short and empty payloads, errors: R6 R10
        setup(6, 0, 7, 30, 0, 2, 0, 1, 0);
        do_reset(); run_frames(0);
        // variable gap with mod-8 wrap: R9
        setup(10, 0, 3, 5, 1, 1, 1, 1, 0);
        do_reset(); run_frames(0);
        // zero frames: R1
        setup(0, 64, 1, 100, 1, 0, 0, 0, 0);
        do_reset(); run_frames(0);
        // oversize: R3
        setup(2, 1600, 10, 2000, 0, 0, 0, 0, 0);
        do_reset(); run_frames(0);
        // pause held from reset, then mid-frame request: R11
        setup(3, 50, 5, 200, 1, 0, 0, 0, 1);
        pause_req = 1'b1;
        do_reset();
        still = 0;
        repeat (40) begin
            if (gmii_tx_en) still++;
            @(negedge clk);
        end
        chk(still == 0, "R11 no start while paused", still, 0);
        pause_req = 1'b0;
        run_frames(1);
        // request ignored when disabled: R12
        setup(3, 20, 4, 200, 1, 0, 0, 0, 0);
        pause_req = 1'b1;
        do_reset(); run_frames(0);
        pause_req = 1'b0;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 got %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule